// File: doc/BRIEF.md
# Echo Canceller Channel Path Controller

This block stands between a time-division multiplexed PCM port and a per-channel echo-cancellation engine. The port hands over one 8-bit sample per slot for the receive direction and one for the send direction, and marks channel 0 of each frame. The block works out the channel from the slot position. It keeps a per-channel history so that every sample leaves on its own channel a fixed number of frames after it entered. That number is two frames on the receive path. On the send path it is three frames, or two frames in bypass.

A four-bit mode word controls the two paths. It can mute either path, which replaces the output with a quiet code. It can bypass the canceller, so the raw send sample goes out. It can freeze learning: the coefficient-update enable stays low while cancellation goes on. The mode word is captured only on the first slot of a frame. The filter arithmetic is replaced by a stub whose "cancelled" sample is the send sample XOR the receive sample of the same slot.

Top module: `ecp_path_ctrl`

## Requirements
- R1: Each slot with `sample_valid_i` high yields, on the next clock, `out_valid_o` high with `out_chan_o` equal to the slot's channel. The channel is 0 on a slot with `frame_start_i` high and increments by one on each later valid slot. A cycle without a valid slot gives `out_valid_o` low on the next clock.
- R2: When receive mute is off, `rout_o` for channel c carries the `rin_i` sample of channel c from exactly two frames earlier. This holds in every mode.
- R3: When bypass and send mute are off, `sout_o` for channel c carries `sin_i ^ rin_i` of channel c from exactly three frames earlier. This is the stub canceller output.
- R4: When bypass (mode bit 2) is on and send mute is off, `sout_o` for channel c carries the raw `sin_i` of channel c from exactly two frames earlier.
- R5: When receive mute (mode bit 0) is on, `rout_o` is 8'hFF.
- R6: When send mute (mode bit 1) is on, `sout_o` is 8'hFF. This applies in bypass as well.
- R7: When bypass and adaptation-disable are both off, `adapt_en_o` and `cancel_en_o` are both high on every output slot.
- R8: When adaptation-disable (mode bit 3) is on without bypass, `adapt_en_o` is low, `cancel_en_o` is high, and `sout_o` still follows R3. In bypass both enables are low.
- R9: The mode word is sampled only on a valid slot with `frame_start_i` high, and it governs all outputs of that frame. Changes of `mode_i` at any other slot have no effect until the next frame start.
- R10: After reset, `out_valid_o`, `out_chan_o`, `rout_o`, `sout_o` and both enables are zero. The history is zero, so samples read out before enough frames have passed are 0. The reset mode is adaptation on, with bypass and both mutes off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | A slot is presented this cycle |
| frame_start_i | input | 1 | The presented slot is channel 0 |
| mode_i | input | 4 | {adapt_dis, bypass, mute_tx, mute_rx} |
| rin_i | input | 8 | Receive-path input sample |
| sin_i | input | 8 | Send-path input sample |
| out_valid_o | output | 1 | Output slot valid |
| out_chan_o | output | 5 | Channel of the output slot |
| rout_o | output | 8 | Receive-path output sample |
| sout_o | output | 8 | Send-path output sample |
| adapt_en_o | output | 1 | Coefficient-update enable to the filter |
| cancel_en_o | output | 1 | Cancellation enable to the filter |

## Verification
The assertions check the following on every cycle: the valid pulse follows one cycle after a slot, channel 0 follows a frame start, the quiet codes and enable levels follow a captured mode, and the enables hold steady inside a frame. The frame delays on each path cannot be seen in a single cycle. Neither can the switch of the send path to raw data in bypass, or the zero history after reset. Only the bench can show these: it logs every sample it sends and compares each output with the sample from two or three frames earlier. It also changes the mode word in the middle of frames.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  typedef struct packed {
    logic adapt_dis;
    logic bypass;
    logic mute_tx;
    logic mute_rx;
  } mode_t;

  localparam mode_t MODE_RESET = '{adapt_dis: 1'b0, bypass: 1'b0, mute_tx: 1'b0, mute_rx: 1'b0};
endpackage

// File: rtl/ecp_slot_seq.sv
module ecp_slot_seq
  import ecp_pkg::*;
#(
  parameter int N_CH = 32,
  localparam int CW = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          fstart_i,
  input  mode_t         mode_i,
  output logic [CW-1:0] chan_o,
  output mode_t         mode_o
);
  logic [CW-1:0] chan_q;
  mode_t         mode_q;
  logic          take_mode;

  assign take_mode = valid_i & fstart_i;

  always_comb begin
    chan_o = fstart_i ? '0 : chan_q;
    mode_o = take_mode ? mode_i : mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      mode_q <= MODE_RESET;
    end else begin
      if (valid_i) chan_q <= chan_o + CW'(1);
      if (take_mode) mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/ecp_delay_bank.sv
module ecp_delay_bank #(
  parameter int N_CH  = 32,
  parameter int DEPTH = 2,
  parameter int W     = 8,
  localparam int CW = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic [CW-1:0] chan_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o
);
  logic [W-1:0] mem_q [N_CH][DEPTH];

  // oldest entry of the addressed channel, read before this slot's shift
  assign dout_o = mem_q[chan_i][DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CH; c++)
        for (int d = 0; d < DEPTH; d++)
          mem_q[c][d] <= '0;
    end else if (shift_i) begin
      mem_q[chan_i][0] <= din_i;
      for (int d = 1; d < DEPTH; d++)
        mem_q[chan_i][d] <= mem_q[chan_i][d-1];
    end
  end
endmodule

// File: rtl/ecp_ec_stub.sv
module ecp_ec_stub #(
  parameter int W = 8
) (
  input  logic [W-1:0] near_i,
  input  logic [W-1:0] far_i,
  output logic [W-1:0] res_o
);
  // placeholder for the adaptive filter: near-end minus modelled echo
  assign res_o = near_i ^ far_i;
endmodule

// File: rtl/ecp_path_ctrl.sv
module ecp_path_ctrl
  import ecp_pkg::*;
#(
  parameter int          N_CH      = 32,
  parameter int          W         = 8,
  parameter int          RX_FRAMES = 2,
  parameter int          TX_FRAMES = 3,
  parameter logic [7:0]  QUIET     = 8'hFF,
  localparam int CW = $clog2(N_CH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_valid_i,
  input  logic          frame_start_i,
  input  logic [3:0]    mode_i,
  input  logic [W-1:0]  rin_i,
  input  logic [W-1:0]  sin_i,
  output logic          out_valid_o,
  output logic [CW-1:0] out_chan_o,
  output logic [W-1:0]  rout_o,
  output logic [W-1:0]  sout_o,
  output logic          adapt_en_o,
  output logic          cancel_en_o
);
  localparam int BYP_FRAMES = RX_FRAMES;
  localparam logic [W-1:0] QUIET_W = W'(QUIET);

  logic [CW-1:0] chan;
  mode_t         mode;
  logic [W-1:0]  ec_res, rx_old, tx_old, byp_old;
  logic [W-1:0]  rout_d, sout_d;

  ecp_slot_seq #(.N_CH(N_CH)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (sample_valid_i),
    .fstart_i (frame_start_i),
    .mode_i   (mode_t'(mode_i)),
    .chan_o   (chan),
    .mode_o   (mode)
  );

  ecp_ec_stub #(.W(W)) u_ec (
    .near_i (sin_i),
    .far_i  (rin_i),
    .res_o  (ec_res)
  );

  ecp_delay_bank #(.N_CH(N_CH), .DEPTH(RX_FRAMES), .W(W)) u_rx_dly (
    .clk_i (clk_i), .rst_ni (rst_ni), .shift_i (sample_valid_i),
    .chan_i (chan), .din_i (rin_i), .dout_o (rx_old)
  );

  ecp_delay_bank #(.N_CH(N_CH), .DEPTH(TX_FRAMES), .W(W)) u_tx_dly (
    .clk_i (clk_i), .rst_ni (rst_ni), .shift_i (sample_valid_i),
    .chan_i (chan), .din_i (ec_res), .dout_o (tx_old)
  );

  ecp_delay_bank #(.N_CH(N_CH), .DEPTH(BYP_FRAMES), .W(W)) u_byp_dly (
    .clk_i (clk_i), .rst_ni (rst_ni), .shift_i (sample_valid_i),
    .chan_i (chan), .din_i (sin_i), .dout_o (byp_old)
  );

  always_comb begin
    rout_d = mode.mute_rx ? QUIET_W : rx_old;
    if (mode.mute_tx)     sout_d = QUIET_W;
    else if (mode.bypass) sout_d = byp_old;
    else                  sout_d = tx_old;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_chan_o  <= '0;
      rout_o      <= '0;
      sout_o      <= '0;
      adapt_en_o  <= 1'b0;
      cancel_en_o <= 1'b0;
    end else begin
      out_valid_o <= sample_valid_i;
      adapt_en_o  <= sample_valid_i & ~mode.bypass & ~mode.adapt_dis;
      cancel_en_o <= sample_valid_i & ~mode.bypass;
      if (sample_valid_i) begin
        out_chan_o <= chan;
        rout_o     <= rout_d;
        sout_o     <= sout_d;
      end
    end
  end
endmodule

// File: rtl/ecp_path_ctrl_chk.sv
module ecp_path_ctrl_chk #(
  parameter int W  = 8,
  parameter int CW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sample_valid_i,
  input logic          frame_start_i,
  input logic [3:0]    mode_i,
  input logic          out_valid_o,
  input logic [CW-1:0] out_chan_o,
  input logic [W-1:0]  rout_o,
  input logic [W-1:0]  sout_o,
  input logic          adapt_en_o,
  input logic          cancel_en_o
);
  // R1
  valid_follows_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_i |=> out_valid_o);
  // R1
  idle_follows_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !out_valid_o);
  // R1
  chan_zero_at_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && frame_start_i) |=> (out_chan_o == '0));
  // R5
  mute_rx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && frame_start_i && mode_i[0]) |=> (rout_o == 8'hFF));
  // R6
  mute_tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && frame_start_i && mode_i[1]) |=> (sout_o == 8'hFF));
  // R8
  freeze_keeps_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && frame_start_i && mode_i[3] && !mode_i[2]) |=> (!adapt_en_o && cancel_en_o));
  // R7
  normal_enables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && frame_start_i && mode_i[3:2] == 2'b00) |=> (adapt_en_o && cancel_en_o));
  // R9
  enables_steady_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && !frame_start_i && out_valid_o) |=>
      (adapt_en_o == $past(adapt_en_o) && cancel_en_o == $past(cancel_en_o)));
  // R10
  enables_need_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (!adapt_en_o && !cancel_en_o));
endmodule

bind ecp_path_ctrl ecp_path_ctrl_chk #(.W(W), .CW(CW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .frame_start_i  (frame_start_i),
  .mode_i         (mode_i),
  .out_valid_o    (out_valid_o),
  .out_chan_o     (out_chan_o),
  .rout_o         (rout_o),
  .sout_o         (sout_o),
  .adapt_en_o     (adapt_en_o),
  .cancel_en_o    (cancel_en_o)
);

// File: tb/tb_ecp_path_ctrl.sv
module tb_ecp_path_ctrl;
  localparam int N_CH = 32;
  localparam int NF   = 40;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sample_valid_i = 1'b0;
  logic       frame_start_i = 1'b0;
  logic [3:0] mode_i = 4'd0;
  logic [7:0] rin_i = 8'd0;
  logic [7:0] sin_i = 8'd0;
  logic       out_valid_o;
  logic [4:0] out_chan_o;
  logic [7:0] rout_o, sout_o;
  logic       adapt_en_o, cancel_en_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] rin_log [NF][N_CH];
  logic [7:0] sin_log [NF][N_CH];
  logic [3:0] fmode   [NF];

  ecp_path_ctrl dut (.*);

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v, input string what);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp_v);
    end
  endtask

  function automatic logic [7:0] exp_rx(input int f, input int c);
    if (fmode[f][0]) return 8'hFF;
    return (f >= 2) ? rin_log[f-2][c] : 8'h00;
  endfunction

  function automatic logic [7:0] exp_tx(input int f, input int c);
    if (fmode[f][1]) return 8'hFF;
    if (fmode[f][2]) return (f >= 2) ? sin_log[f-2][c] : 8'h00;
    return (f >= 3) ? (sin_log[f-3][c] ^ rin_log[f-3][c]) : 8'h00;
  endfunction

  function automatic string tag_rx(input int f);
    return fmode[f][0] ? "R5" : "R2";
  endfunction

  function automatic string tag_tx(input int f);
    if (fmode[f][1]) return "R6";
    if (fmode[f][2]) return "R4";
    if (fmode[f][3]) return "R8";
    return "R3";
  endfunction

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    // R10
    chk("R10", {31'd0, out_valid_o}, 0, "valid in reset");
    chk("R10", {27'd0, out_chan_o}, 0, "chan in reset");
    chk("R10", {16'd0, rout_o, sout_o}, 0, "data in reset");
    chk("R10", {30'd0, adapt_en_o, cancel_en_o}, 0, "enables in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10", {31'd0, out_valid_o}, 0, "valid after release");

    for (int f = 0; f < NF; f++) begin
      logic [3:0] m;
      int mid;
      case (f)
        0, 1, 2, 3: m = 4'b0000;
        4: m = 4'b0100;
        5: m = 4'b1000;
        6: m = 4'b0011;
        7: m = 4'b0110;
        8: m = 4'b0000;
        default: m = 4'($urandom_range(0, 15));
      endcase
      fmode[f] = m;
      mid = (f >= 3) ? int'($urandom_range(1, N_CH - 1)) : N_CH;
      // occasional idle gap between frames
      if (f > 0 && ($urandom_range(0, 2) == 0)) begin
        sample_valid_i = 1'b0;
        frame_start_i  = 1'b0;
        mode_i         = ~m;
        @(negedge clk_i);
        // R1
        chk("R1", {31'd0, out_valid_o}, 0, "valid after idle cycle");
      end
      for (int c = 0; c < N_CH; c++) begin
        logic [7:0] r, s;
        r = (f == 9 && c < 2) ? 8'hFF : 8'($urandom);
        s = (f == 9 && c < 2) ? 8'h00 : 8'($urandom);
        rin_log[f][c] = r;
        sin_log[f][c] = s;
        sample_valid_i = 1'b1;
        frame_start_i  = (c == 0);
        rin_i = r;
        sin_i = s;
        if (c == 0) mode_i = m;
        else if (c == mid) mode_i = 4'($urandom_range(0, 15)); // R9: ignored mid-frame
        @(negedge clk_i);
        chk("R1", {31'd0, out_valid_o}, 1, "valid");
        chk("R1", {27'd0, out_chan_o}, c, "channel");
        chk((c > mid) ? "R9" : tag_rx(f), {24'd0, rout_o}, {24'd0, exp_rx(f, c)}, "rout");
        chk((c > mid) ? "R9" : tag_tx(f), {24'd0, sout_o}, {24'd0, exp_tx(f, c)}, "sout");
        chk(m[2] ? "R8" : (m[3] ? "R8" : "R7"), {31'd0, adapt_en_o},
            {31'd0, ~m[2] & ~m[3]}, "adapt_en");
        chk(m[2] ? "R8" : "R7", {31'd0, cancel_en_o}, {31'd0, ~m[2]}, "cancel_en");
      end
    end
    sample_valid_i = 1'b0;
    frame_start_i  = 1'b0;
    @(negedge clk_i);
    chk("R1", {31'd0, out_valid_o}, 0, "valid after last slot");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule